// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer

This block translates 32-bit effective addresses into physical addresses through a small, fully associative table of 32 translations. Each slot holds a virtual page number, a physical frame number, the address-space ID that owns it, a protection-group number and a page size. On a lookup, every slot is compared at the same time. The page size of a slot decides how many upper address bits take part in the compare and how many low bits pass through untranslated. After the match, the permission of the matching slot's group is applied to the access type. This can turn a hit into a protection fault.

Software fills the table through a write port. The write either names a slot directly or leaves the choice to a round-robin replacement pointer. A single invalidate pulse empties the whole table. A separate write port loads the per-group permission word. Table walking on a miss and any interaction with caches stay outside the block.

The lookup result is held in a four-state response register: RS_IDLE (no lookup was presented), RS_MISS, RS_HIT and RS_FAULT. On every clock edge the next state is chosen from the inputs alone:
- no request gives RS_IDLE;
- a request with no matching slot gives RS_MISS;
- a match whose group allows the access gives RS_HIT;
- a match whose group forbids it gives RS_FAULT.

Every state can move to any of the four. Reset enters RS_IDLE.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup presented with `lk_req_i` high at a clock edge is answered on the outputs after that edge: `lk_rsp_o` is high for exactly that one cycle, and all 32 slots take part in the compare.
- R2: Page-size code: 00 = 4 KiB, 01 = 16 KiB, 10 = 512 KiB, 11 = 8 MiB. The code makes the compare use the upper 20, 18, 13 or 9 bits of the effective address against the stored page number (bits 31:12 of the stored base).
- R3: The physical address of a hit is the stored frame base for address bits at or above the page-offset boundary, and the effective address below it. Frame bits under the boundary are ignored.
- R4: A slot can hit only when it is valid and its stored 4-bit address-space ID equals `lk_asid_i`.
- R5: The permission word holds 2 bits for group g at bits [2g+1:2g] and resets to all zeros. Permission codes: 00 = no access, 01 = read only, 10 = read/write, 11 = no access. Access type `lk_wr_i`: 0 = read, 1 = write. A hit whose group forbids the access gives `lk_hit_o`=1 and `lk_fault_o`=1, and the physical address is still driven.
- R6: On a miss, `lk_hit_o`, `lk_fault_o` and `lk_pa_o` are all zero.
- R7: A write with `wr_use_slot_i`=1 loads slot `wr_slot_i` and makes it valid. This replaces any earlier contents of that slot.
- R8: The replacement pointer resets to 0. A write with `wr_use_slot_i`=0 loads the slot under the pointer and then advances the pointer by one, wrapping from 31 to 0. Named-slot writes leave the pointer unchanged.
- R9: When more than one valid slot matches, the lowest-numbered slot supplies the translation and the group.
- R10: `flush_i` makes every slot invalid at the next edge. A write in the same cycle is dropped and does not advance the pointer.
- R11: After reset every slot is invalid and `lk_rsp_o`, `lk_hit_o` and `lk_fault_o` are 0.
- R12: With no request at an edge, the following cycle shows `lk_rsp_o`, `lk_hit_o` and `lk_fault_o` all 0.
- R13: A lookup in the same cycle as a write or a flush sees the table contents from before that write or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Effective address to translate |
| lk_asid_i | input | 4 | Address-space ID of the request |
| lk_wr_i | input | 1 | Access type: 0 read, 1 write |
| lk_rsp_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A valid slot matched |
| lk_fault_o | output | 1 | Matched but access forbidden by group permission |
| lk_pa_o | output | 32 | Translated physical address, zero on miss |
| wr_en_i | input | 1 | Load a translation |
| wr_use_slot_i | input | 1 | 1: use wr_slot_i, 0: use the replacement pointer |
| wr_slot_i | input | 5 | Target slot for named writes |
| wr_vpn_i | input | 20 | Virtual page number (address bits 31:12) |
| wr_ppn_i | input | 20 | Physical frame number (address bits 31:12) |
| wr_asid_i | input | 4 | Owning address-space ID |
| wr_grp_i | input | 4 | Protection group |
| wr_size_i | input | 2 | Page-size code |
| perm_we_i | input | 1 | Load the group permission word |
| perm_data_i | input | 32 | Permission word, 2 bits per group |
| flush_i | input | 1 | Invalidate all slots |

## Verification
The bench builds the block with its defaults: 32 slots, 4-bit address-space IDs and 16 protection groups. With these values, a full lap of the replacement pointer takes only 32 writes, so the wrap from slot 31 back to slot 0 is reached and checked. It also checks that named writes between pointer writes do not disturb the pointer. All four page sizes sit in the table at the same time, so each compare width is probed on both sides of its page boundary. Two address-space IDs and all four permission codes are exercised against reads and writes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Page-size code held per slot
    typedef enum logic [1:0] {
        PG_4K   = 2'b00,
        PG_16K  = 2'b01,
        PG_512K = 2'b10,
        PG_8M   = 2'b11
    } pg_size_e;

    // Per-group permission code
    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_RSVD = 2'b11
    } perm_e;

    // Registered lookup outcome
    typedef enum logic [1:0] {
        RS_IDLE  = 2'b00,
        RS_MISS  = 2'b01,
        RS_HIT   = 2'b10,
        RS_FAULT = 2'b11
    } rsp_state_e;

    // Smallest page offset: stored page numbers start at this bit
    localparam int unsigned MIN_OFF = 12;

    // Number of untranslated low bits for each page size
    function automatic int unsigned pg_offset_bits(pg_size_e s);
        int unsigned r;
        unique case (s)
            PG_4K:   r = 12;
            PG_16K:  r = 14;
            PG_512K: r = 19;
            PG_8M:   r = 23;
            default: r = 12;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank
    import tlb_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ASID_W      = 4,
    parameter int unsigned GRP_W       = 4,
    localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
    localparam int unsigned PN_W       = ADDR_W - MIN_OFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   wr_en_i,
    input  logic                   wr_use_slot_i,
    input  logic [IDX_W-1:0]       wr_slot_i,
    input  logic [PN_W-1:0]        wr_vpn_i,
    input  logic [PN_W-1:0]        wr_ppn_i,
    input  logic [ASID_W-1:0]      wr_asid_i,
    input  logic [GRP_W-1:0]       wr_grp_i,
    input  pg_size_e               wr_size_i,
    input  logic [ADDR_W-1:0]      lk_ea_i,
    input  logic [ASID_W-1:0]      lk_asid_i,
    output logic [NUM_ENTRIES-1:0] match_o,
    output logic [NUM_ENTRIES-1:0] valid_o,
    output logic [ADDR_W-1:0]      cand_pa_o  [NUM_ENTRIES],
    output logic [GRP_W-1:0]       cand_grp_o [NUM_ENTRIES],
    output logic [IDX_W-1:0]       rr_ptr_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] tgt;
    logic             wr_go;
    logic             rr_adv;

    assign wr_go  = wr_en_i && !flush_i;
    assign rr_adv = wr_go && !wr_use_slot_i;
    assign tgt    = wr_use_slot_i ? wr_slot_i : rr_q;

    // Round-robin replacement pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (rr_adv) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

    assign rr_ptr_o = rr_q;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        logic              vld_q;
        logic [PN_W-1:0]   vpn_q;
        logic [PN_W-1:0]   ppn_q;
        logic [ASID_W-1:0] asid_q;
        logic [GRP_W-1:0]  grp_q;
        pg_size_e          size_q;
        logic              sel;
        logic [ADDR_W-1:0] cmp_mask;
        logic [ADDR_W-1:0] vbase;
        logic [ADDR_W-1:0] pbase;

        assign sel = wr_go && (tgt == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (flush_i) begin
                vld_q <= 1'b0;
            end else if (sel) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                vpn_q  <= wr_vpn_i;
                ppn_q  <= wr_ppn_i;
                asid_q <= wr_asid_i;
                grp_q  <= wr_grp_i;
                size_q <= wr_size_i;
            end
        end

        // Compare mask keeps only the bits above this slot's page offset
        assign cmp_mask = {ADDR_W{1'b1}} << pg_offset_bits(size_q);
        assign vbase    = {vpn_q, {MIN_OFF{1'b0}}};
        assign pbase    = {ppn_q, {MIN_OFF{1'b0}}};

        assign match_o[g]    = vld_q && (asid_q == lk_asid_i) &&
                               (((lk_ea_i ^ vbase) & cmp_mask) == '0);
        assign valid_o[g]    = vld_q;
        assign cand_pa_o[g]  = (pbase & cmp_mask) | (lk_ea_i & ~cmp_mask);
        assign cand_grp_o[g] = grp_q;
    end

endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned GRP_W       = 4
) (
    input  logic [NUM_ENTRIES-1:0] match_i,
    input  logic [ADDR_W-1:0]      cand_pa_i  [NUM_ENTRIES],
    input  logic [GRP_W-1:0]       cand_grp_i [NUM_ENTRIES],
    output logic                   found_o,
    output logic [ADDR_W-1:0]      pa_o,
    output logic [GRP_W-1:0]       grp_o
);

    // Scan from the top down so the lowest matching slot is applied last
    always_comb begin
        found_o = 1'b0;
        pa_o    = '0;
        grp_o   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                found_o = 1'b1;
                pa_o    = cand_pa_i[i];
                grp_o   = cand_grp_i[i];
            end
        end
    end

endmodule

// File: rtl/tlb_perm_table.sv
module tlb_perm_table
    import tlb_pkg::*;
#(
    parameter int unsigned GRP_W  = 4,
    localparam int unsigned NGRP  = 1 << GRP_W,
    localparam int unsigned PERM_W = 2 * NGRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PERM_W-1:0] data_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic              acc_wr_i,
    output logic              allow_o
);

    logic [PERM_W-1:0] tbl_q;
    perm_e             code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (we_i) begin
            tbl_q <= data_i;
        end
    end

    assign code = perm_e'(tbl_q[2*grp_i +: 2]);

    always_comb begin
        unique case (code)
            PERM_RO:   allow_o = !acc_wr_i;
            PERM_RW:   allow_o = 1'b1;
            PERM_NONE: allow_o = 1'b0;
            PERM_RSVD: allow_o = 1'b0;
            default:   allow_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tlb_resp_fsm.sv
module tlb_resp_fsm
    import tlb_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              found_i,
    input  logic              allow_i,
    input  logic [ADDR_W-1:0] pa_i,
    output logic              rsp_o,
    output logic              hit_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] pa_o
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [ADDR_W-1:0] pa_q;

    // Next state depends only on this cycle's lookup
    always_comb begin
        if (!req_i) begin
            state_d = RS_IDLE;
        end else if (!found_i) begin
            state_d = RS_MISS;
        end else if (allow_i) begin
            state_d = RS_HIT;
        end else begin
            state_d = RS_FAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= (req_i && found_i) ? pa_i : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:  begin rsp_o = 1'b0; hit_o = 1'b0; fault_o = 1'b0; end
            RS_MISS:  begin rsp_o = 1'b1; hit_o = 1'b0; fault_o = 1'b0; end
            RS_HIT:   begin rsp_o = 1'b1; hit_o = 1'b1; fault_o = 1'b0; end
            RS_FAULT: begin rsp_o = 1'b1; hit_o = 1'b1; fault_o = 1'b1; end
            default:  begin rsp_o = 1'b0; hit_o = 1'b0; fault_o = 1'b0; end
        endcase
        pa_o = pa_q;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ASID_W      = 4,
    parameter int unsigned GRP_W       = 4,
    localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
    localparam int unsigned PN_W       = ADDR_W - MIN_OFF,
    localparam int unsigned PERM_W     = 2 * (1 << GRP_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req_i,
    input  logic [ADDR_W-1:0] lk_ea_i,
    input  logic [ASID_W-1:0] lk_asid_i,
    input  logic              lk_wr_i,
    output logic              lk_rsp_o,
    output logic              lk_hit_o,
    output logic              lk_fault_o,
    output logic [ADDR_W-1:0] lk_pa_o,
    input  logic              wr_en_i,
    input  logic              wr_use_slot_i,
    input  logic [IDX_W-1:0]  wr_slot_i,
    input  logic [PN_W-1:0]   wr_vpn_i,
    input  logic [PN_W-1:0]   wr_ppn_i,
    input  logic [ASID_W-1:0] wr_asid_i,
    input  logic [GRP_W-1:0]  wr_grp_i,
    input  logic [1:0]        wr_size_i,
    input  logic              perm_we_i,
    input  logic [PERM_W-1:0] perm_data_i,
    input  logic              flush_i
);

    logic [NUM_ENTRIES-1:0] match;
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic [ADDR_W-1:0]      cand_pa  [NUM_ENTRIES];
    logic [GRP_W-1:0]       cand_grp [NUM_ENTRIES];
    logic [IDX_W-1:0]       rr_ptr;
    logic                   found;
    logic [ADDR_W-1:0]      sel_pa;
    logic [GRP_W-1:0]       sel_grp;
    logic                   allow;

    tlb_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W),
        .ASID_W      (ASID_W),
        .GRP_W       (GRP_W)
    ) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .wr_en_i       (wr_en_i),
        .wr_use_slot_i (wr_use_slot_i),
        .wr_slot_i     (wr_slot_i),
        .wr_vpn_i      (wr_vpn_i),
        .wr_ppn_i      (wr_ppn_i),
        .wr_asid_i     (wr_asid_i),
        .wr_grp_i      (wr_grp_i),
        .wr_size_i     (pg_size_e'(wr_size_i)),
        .lk_ea_i       (lk_ea_i),
        .lk_asid_i     (lk_asid_i),
        .match_o       (match),
        .valid_o       (ent_valid),
        .cand_pa_o     (cand_pa),
        .cand_grp_o    (cand_grp),
        .rr_ptr_o      (rr_ptr)
    );

    tlb_prio_pick #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W),
        .GRP_W       (GRP_W)
    ) u_pick (
        .match_i    (match),
        .cand_pa_i  (cand_pa),
        .cand_grp_i (cand_grp),
        .found_o    (found),
        .pa_o       (sel_pa),
        .grp_o      (sel_grp)
    );

    tlb_perm_table #(
        .GRP_W (GRP_W)
    ) u_perm (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (perm_we_i),
        .data_i   (perm_data_i),
        .grp_i    (sel_grp),
        .acc_wr_i (lk_wr_i),
        .allow_o  (allow)
    );

    tlb_resp_fsm #(
        .ADDR_W (ADDR_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (lk_req_i),
        .found_i (found),
        .allow_i (allow),
        .pa_i    (sel_pa),
        .rsp_o   (lk_rsp_o),
        .hit_o   (lk_hit_o),
        .fault_o (lk_fault_o),
        .pa_o    (lk_pa_o)
    );

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int unsigned NUM_ENTRIES = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_req_i,
    input logic                   lk_rsp_o,
    input logic                   lk_hit_o,
    input logic                   lk_fault_o,
    input logic [ADDR_W-1:0]      lk_pa_o,
    input logic                   wr_en_i,
    input logic                   wr_use_slot_i,
    input logic [IDX_W-1:0]       wr_slot_i,
    input logic                   flush_i,
    input logic [NUM_ENTRIES-1:0] ent_valid,
    input logic [IDX_W-1:0]       rr_ptr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_i |=> lk_rsp_o);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req_i |=> (!lk_rsp_o && !lk_hit_o && !lk_fault_o));

    p_fault_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault_o |-> lk_hit_o);

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_o && !lk_hit_o) |-> (lk_pa_o == '0 && !lk_fault_o));

    p_named_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_use_slot_i && !flush_i) |=> ent_valid[$past(wr_slot_i)]);

    p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_use_slot_i && !flush_i) |=>
        (rr_ptr == (($past(rr_ptr) == LAST_IDX) ? '0 : $past(rr_ptr) + 1'b1)));

    p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i || !wr_en_i || wr_use_slot_i) |=> $stable(rr_ptr));

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ent_valid == '0));

endmodule

bind tlb_xlate tlb_xlate_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req_i      (lk_req_i),
    .lk_rsp_o      (lk_rsp_o),
    .lk_hit_o      (lk_hit_o),
    .lk_fault_o    (lk_fault_o),
    .lk_pa_o       (lk_pa_o),
    .wr_en_i       (wr_en_i),
    .wr_use_slot_i (wr_use_slot_i),
    .wr_slot_i     (wr_slot_i),
    .flush_i       (flush_i),
    .ent_valid     (ent_valid),
    .rr_ptr        (rr_ptr)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req_i = 1'b0;
    logic [31:0] lk_ea_i = '0;
    logic [3:0]  lk_asid_i = '0;
    logic        lk_wr_i = 1'b0;
    logic        lk_rsp_o, lk_hit_o, lk_fault_o;
    logic [31:0] lk_pa_o;
    logic        wr_en_i = 1'b0;
    logic        wr_use_slot_i = 1'b0;
    logic [4:0]  wr_slot_i = '0;
    logic [19:0] wr_vpn_i = '0;
    logic [19:0] wr_ppn_i = '0;
    logic [3:0]  wr_asid_i = '0;
    logic [3:0]  wr_grp_i = '0;
    logic [1:0]  wr_size_i = '0;
    logic        perm_we_i = 1'b0;
    logic [31:0] perm_data_i = '0;
    logic        flush_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic        hit;
        logic        fault;
        logic [31:0] pa;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_req_i(lk_req_i), .lk_ea_i(lk_ea_i), .lk_asid_i(lk_asid_i), .lk_wr_i(lk_wr_i),
        .lk_rsp_o(lk_rsp_o), .lk_hit_o(lk_hit_o), .lk_fault_o(lk_fault_o), .lk_pa_o(lk_pa_o),
        .wr_en_i(wr_en_i), .wr_use_slot_i(wr_use_slot_i), .wr_slot_i(wr_slot_i),
        .wr_vpn_i(wr_vpn_i), .wr_ppn_i(wr_ppn_i), .wr_asid_i(wr_asid_i),
        .wr_grp_i(wr_grp_i), .wr_size_i(wr_size_i),
        .perm_we_i(perm_we_i), .perm_data_i(perm_data_i), .flush_i(flush_i)
    );

    // Monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && lk_rsp_o) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected response hit=%0b fault=%0b pa=%h, expected none",
                         lk_hit_o, lk_fault_o, lk_pa_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (lk_hit_o !== e.hit || lk_fault_o !== e.fault || lk_pa_o !== e.pa) begin
                    n_fail++;
                    $display("FAIL %s: got hit=%0b fault=%0b pa=%h, expected hit=%0b fault=%0b pa=%h",
                             e.tag, lk_hit_o, lk_fault_o, lk_pa_o, e.hit, e.fault, e.pa);
                end
            end
        end
    end

    task automatic check_quiet(input string tag);
        n_checks++;
        if (lk_rsp_o !== 1'b0 || lk_hit_o !== 1'b0 || lk_fault_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: got rsp=%0b hit=%0b fault=%0b, expected 0 0 0",
                     tag, lk_rsp_o, lk_hit_o, lk_fault_o);
        end
    endtask

    // Driver: present one lookup for one cycle and queue its expectation
    task automatic lookup(input logic [31:0] ea, input logic [3:0] asid, input logic wr,
                          input logic hit, input logic fault, input logic [31:0] pa,
                          input string tag);
        exp_t e;
        e.hit = hit; e.fault = fault; e.pa = pa; e.tag = tag;
        sb.push_back(e);
        lk_req_i  = 1'b1;
        lk_ea_i   = ea;
        lk_asid_i = asid;
        lk_wr_i   = wr;
        @(negedge clk);
        lk_req_i  = 1'b0;
    endtask

    task automatic set_write(input logic use_slot, input logic [4:0] slot,
                             input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic [3:0] asid, input logic [3:0] grp,
                             input logic [1:0] sz);
        wr_en_i = 1'b1; wr_use_slot_i = use_slot; wr_slot_i = slot;
        wr_vpn_i = vpn; wr_ppn_i = ppn; wr_asid_i = asid; wr_grp_i = grp; wr_size_i = sz;
    endtask

    task automatic load(input logic use_slot, input logic [4:0] slot,
                        input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [3:0] asid, input logic [3:0] grp,
                        input logic [1:0] sz);
        set_write(use_slot, slot, vpn, ppn, asid, grp, sz);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_perm(input logic [31:0] w);
        perm_we_i = 1'b1; perm_data_i = w;
        @(negedge clk);
        perm_we_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R11 reset outputs");
        // R11: empty table after reset
        lookup(32'h1234_5678, 4'd1, 1'b0, 1'b0, 1'b0, 32'h0, "R11 empty table miss");

        // Perm: g0=RW(10), g1=RO(01), g2=none(00), g3=reserved(11)
        set_perm(32'h0000_00C6);

        // Slot 3 named, 4K
        load(1'b1, 5'd3, 20'h12345, 20'hABCDE, 4'd1, 4'd0, 2'b00);
        // Pointer writes: slot0 16K, slot1 512K, slot2 8M
        load(1'b0, 5'd0, 20'h40000, 20'h80004, 4'd5, 4'd1, 2'b01);
        load(1'b0, 5'd0, 20'h00080, 20'h3FF80, 4'd0, 4'd2, 2'b10);
        load(1'b0, 5'd0, 20'hFF800, 20'h01000, 4'd7, 4'd3, 2'b11);

        lookup(32'h1234_5678, 4'd1, 1'b0, 1'b1, 1'b0, 32'hABCD_E678, "R3 4K translate");
        lookup(32'h1234_5678, 4'd2, 1'b0, 1'b0, 1'b0, 32'h0, "R4 asid mismatch");
        lookup(32'h1234_6678, 4'd1, 1'b0, 1'b0, 1'b0, 32'h0, "R2 4K neighbour page");
        lookup(32'h4000_3ABC, 4'd5, 1'b0, 1'b1, 1'b0, 32'h8000_7ABC, "R3 16K offset pass");
        lookup(32'h4000_4000, 4'd5, 1'b0, 1'b0, 1'b0, 32'h0, "R2 16K boundary");
        lookup(32'h4000_3ABC, 4'd5, 1'b1, 1'b1, 1'b1, 32'h8000_7ABC, "R5 read-only write fault");
        lookup(32'h000F_FFFF, 4'd0, 1'b0, 1'b1, 1'b1, 32'h3FFF_FFFF, "R5 no-access fault");
        lookup(32'h0010_0000, 4'd0, 1'b0, 1'b0, 1'b0, 32'h0, "R2 512K boundary");
        lookup(32'hFFFF_FFFF, 4'd7, 1'b0, 1'b1, 1'b1, 32'h017F_FFFF, "R5 reserved code fault");
        lookup(32'hFF80_0000, 4'd7, 1'b1, 1'b1, 1'b1, 32'h0100_0000, "R2 8M base");
        lookup(32'hFF7F_FFFF, 4'd7, 1'b0, 1'b0, 1'b0, 32'h0, "R2 8M boundary");
        @(negedge clk);
        check_quiet("R12 idle cycle");

        // R9: duplicate in slot 10, slot 3 still wins
        load(1'b1, 5'd10, 20'h12345, 20'h11111, 4'd1, 4'd0, 2'b00);
        lookup(32'h1234_5678, 4'd1, 1'b0, 1'b1, 1'b0, 32'hABCD_E678, "R9 lowest slot wins");
        // R7: overwrite slot 3
        load(1'b1, 5'd3, 20'h55555, 20'h22222, 4'd1, 4'd0, 2'b00);
        lookup(32'h1234_5678, 4'd1, 1'b0, 1'b1, 1'b0, 32'h1111_1678, "R7 slot overwrite");
        lookup(32'h5555_5000, 4'd1, 1'b1, 1'b1, 1'b0, 32'h2222_2000, "R5 read-write write ok");

        // R8: 29 pointer writes fill slots 3..31, then wrap to 0
        for (int i = 0; i < 29; i++) begin
            load(1'b0, 5'd0, 20'h70000 + 20'(i), 20'h60000 + 20'(i), 4'd9, 4'd0, 2'b00);
        end
        lookup(32'h7000_0123, 4'd9, 1'b0, 1'b1, 1'b0, 32'h6000_0123, "R8 pointer reached slot 3");
        lookup(32'h7001_CABC, 4'd9, 1'b0, 1'b1, 1'b0, 32'h6001_CABC, "R8 pointer reached slot 31");
        lookup(32'h1234_5678, 4'd1, 1'b0, 1'b0, 1'b0, 32'h0, "R8 slot 10 replaced");
        load(1'b0, 5'd0, 20'h33333, 20'h44444, 4'd2, 4'd0, 2'b00);
        lookup(32'h4000_3ABC, 4'd5, 1'b0, 1'b0, 1'b0, 32'h0, "R8 wrap replaced slot 0");
        lookup(32'h3333_3001, 4'd2, 1'b0, 1'b1, 1'b0, 32'h4444_4001, "R8 wrap new entry");

        // R5: make group 2 read/write
        set_perm(32'h0000_00E6);
        lookup(32'h000F_FFFF, 4'd0, 1'b0, 1'b1, 1'b0, 32'h3FFF_FFFF, "R5 permission reload");

        // R10: flush empties everything
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        lookup(32'h3333_3001, 4'd2, 1'b0, 1'b0, 1'b0, 32'h0, "R10 flush clears");
        lookup(32'h000F_FFFF, 4'd0, 1'b0, 1'b0, 1'b0, 32'h0, "R10 flush clears all");

        // R13: lookup alongside write sees old contents
        set_write(1'b1, 5'd20, 20'h99999, 20'h12121, 4'd3, 4'd0, 2'b00);
        lookup(32'h9999_9ABC, 4'd3, 1'b0, 1'b0, 1'b0, 32'h0, "R13 same-cycle write unseen");
        wr_en_i = 1'b0;
        lookup(32'h9999_9ABC, 4'd3, 1'b0, 1'b1, 1'b0, 32'h1212_1ABC, "R7 named write visible");
        // R13: lookup alongside flush still hits
        flush_i = 1'b1;
        lookup(32'h9999_9ABC, 4'd3, 1'b0, 1'b1, 1'b0, 32'h1212_1ABC, "R13 same-cycle flush unseen");
        flush_i = 1'b0;
        lookup(32'h9999_9ABC, 4'd3, 1'b0, 1'b0, 1'b0, 32'h0, "R10 flush after lookup");

        // R10: flush beats a same-cycle write
        set_write(1'b1, 5'd21, 20'h88888, 20'h77777, 4'd3, 4'd0, 2'b00);
        flush_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        flush_i = 1'b0;
        lookup(32'h8888_8000, 4'd3, 1'b0, 1'b0, 1'b0, 32'h0, "R10 write dropped by flush");

        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1: got %0d unanswered lookups, expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule